// File: doc/BRIEF.md
# Processor Stop-Clock Power State Controller

This block follows the power-management state of a processor core. It takes an active-low stop-clock request, a halt indication from the core, five wake events, an active-low external snoop strobe and a flag that says whether the input clock is running. From these it keeps one of five states: run, stop-granted, clock-stopped, halted and snoop-serviced. It issues one-cycle pulses that ask the bus unit to run a stop-grant or a halt special cycle. It pulses a cache-invalidate strobe when a snoop is serviced, and it enables the core only while in the run state.

Clock loss is modelled rather than real. The controller runs on a free-running reference clock, and `clk_present` low stands for a stopped input clock. One saturating counter measures two windows. The first is the eight clock periods that must pass after entering stop-grant (for example after a frequency change) before a release of the request is honoured. The second is the eight periods of restored clock that lead back from clock-stopped to stop-granted. The stop-clock request, the snoop strobe and all wake inputs pass through a two-flop synchronizer before the state logic sees them. The halt indication and `clk_present` are used directly.

Top module: `pwr_state_ctrl`

## Requirements
- R1: Reset (`rst_n` low, asynchronous) forces state code 0 (run) at once, with `stopgnt_cyc_o`, `halt_cyc_o` and `inval_o` low and `core_run_o` high. This holds from any state.
- R2: In run, a synchronized stop request moves to state code 1 (stop-granted). `stopgnt_cyc_o` is high for exactly the first cycle of that state. When the stop request and the halt indication are both present, the stop request wins.
- R3: In run, `halt_ind` high at a clock edge moves to state code 3 (halted) at that edge. `halt_cyc_o` is high for exactly the first halted cycle.
- R4: In halted, any one of the five wake inputs returns the state to run.
- R5: A stop request in halted also enters stop-granted with a `stopgnt_cyc_o` pulse. Releasing the request returns to the state that preceded stop-granted. A return to halted re-issues a one-cycle `halt_cyc_o` pulse. A return to run issues none.
- R6: A release of the stop request is honoured only after eight full clock-present cycles have passed in stop-granted. With an early release, stop-granted is observed for exactly nine cycles.
- R7: In stop-granted, `clk_present` low moves to state code 2 (clock-stopped) at the next edge, where `core_run_o` is low.
- R8: Once `clk_present` returns, the state goes from clock-stopped to stop-granted at the eighth clock edge with the clock present, when the restart counter reaches exactly eight.
- R9: A falling edge of the synchronized snoop strobe in halted or stop-granted enters state code 4 (snoop) for exactly one cycle, with `inval_o` high in that cycle, and then returns to the state it came from.
- R10: A snoop strobe in run has no effect: the state stays run and `inval_o` stays low.
- R11: `core_run_o` is high only in the run state.
- R12: A change on `stop_req_n`, `snoop_n` or a wake input takes effect at the third rising clock edge after it is applied, and not earlier.
- R13: Wake inputs have no effect in stop-granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stop_req_n | input | 1 | Active-low stop-clock request |
| halt_ind | input | 1 | Core has executed a halt instruction |
| wake_intr | input | 1 | Maskable interrupt wake event |
| wake_nmi | input | 1 | Non-maskable interrupt wake event |
| wake_smi | input | 1 | System-management interrupt wake event |
| wake_rst | input | 1 | Hard reset request wake event |
| wake_srst | input | 1 | Soft reset wake event |
| snoop_n | input | 1 | Active-low external snoop strobe |
| clk_present | input | 1 | High while the input clock is running |
| state_o | output | 3 | Current state code: 0 run, 1 stop-granted, 2 clock-stopped, 3 halted, 4 snoop |
| stopgnt_cyc_o | output | 1 | One-cycle request for a stop-grant bus cycle |
| halt_cyc_o | output | 1 | One-cycle request for a halt bus cycle |
| inval_o | output | 1 | One-cycle cache-invalidate strobe |
| core_run_o | output | 1 | Core execution enable |

## Verification
The bench uses the default parameters: a restart count of eight and a synchronizer depth of two. With these, both eight-cycle windows and the three-edge input latency can be checked at their exact edges: one cycle before the window closes and the cycle it closes. Short directed scenarios check every transition, each return path and the ignored inputs this way.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

  // State codes are visible on the state output; the bench decodes them.
  typedef enum logic [2:0] {
    PS_RUN     = 3'd0,
    PS_GRANT   = 3'd1,
    PS_STOPPED = 3'd2,
    PS_HALTED  = 3'd3,
    PS_SNOOP   = 3'd4
  } pwr_state_e;

  localparam int NUM_WAKE = 5;

endpackage

// File: rtl/pwr_sync.sv
// Multi-stage synchronizer bank with a per-bit reset value.
module pwr_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/pwr_restart_cnt.sv
// Saturating counter for the eight-period restart and settle windows.
module pwr_restart_cnt #(
  parameter int LIMIT = 8,
  parameter int CW    = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          clr_i,    // clear has priority over counting
  input  logic          run_i,    // clock present this cycle
  output logic [CW-1:0] cnt_o,
  output logic          done_o,   // count has reached LIMIT
  output logic          hit_o     // count reaches LIMIT at this edge
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          inc;

  assign done_o = (cnt_q == CW'(LIMIT));
  assign inc    = run_i && !done_o;
  assign hit_o  = inc && !clr_i && (cnt_q == CW'(LIMIT - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)    cnt_d = '0;
    else if (inc) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R8: the counter saturates and never runs past the limit
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_q <= CW'(LIMIT));

  // R8: once saturated, only a clear moves it
  p_cnt_hold_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (done_o && !clr_i) |=> (cnt_q == CW'(LIMIT)));

endmodule

// File: rtl/pwr_fsm.sv
// Five-state power controller: next-state logic and registers.
module pwr_fsm
  import pwr_pkg::*;
#(
  parameter int LIMIT = 8,
  parameter int CW    = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          stop_req,     // synchronized, active high
  input  logic          halt_ind,
  input  logic          wake_any,     // synchronized
  input  logic          snoop_act,    // synchronized, active high
  input  logic          clk_present,
  input  logic          cnt_done,
  input  logic          cnt_hit,
  input  logic [CW-1:0] cnt_q,
  output pwr_state_e    state_q,
  output logic          grant_entry,  // clears the settle counter
  output logic          stopgnt_cyc_q,
  output logic          halt_cyc_q,
  output logic          inval_q
);

  pwr_state_e state_d;
  logic       ret_halt_q, ret_halt_d;    // stop-granted returns to halted
  logic       snp_grant_q, snp_grant_d;  // snoop returns to stop-granted
  logic       snoop_prev_q;
  logic       snoop_evt;
  logic       sg_pulse_d, halt_pulse_d, inval_d;

  assign snoop_evt = snoop_act && !snoop_prev_q;

  always_comb begin
    state_d      = state_q;
    ret_halt_d   = ret_halt_q;
    snp_grant_d  = snp_grant_q;
    sg_pulse_d   = 1'b0;
    halt_pulse_d = 1'b0;
    inval_d      = 1'b0;
    grant_entry  = 1'b0;
    unique case (state_q)
      PS_RUN: begin
        if (stop_req) begin
          state_d     = PS_GRANT;
          ret_halt_d  = 1'b0;
          sg_pulse_d  = 1'b1;
          grant_entry = 1'b1;
        end else if (halt_ind) begin
          state_d      = PS_HALTED;
          halt_pulse_d = 1'b1;
        end
      end
      PS_HALTED: begin
        if (wake_any) begin
          state_d = PS_RUN;
        end else if (stop_req) begin
          state_d     = PS_GRANT;
          ret_halt_d  = 1'b1;
          sg_pulse_d  = 1'b1;
          grant_entry = 1'b1;
        end else if (snoop_evt) begin
          state_d     = PS_SNOOP;
          snp_grant_d = 1'b0;
          inval_d     = 1'b1;
        end
      end
      PS_GRANT: begin
        if (!clk_present) begin
          state_d = PS_STOPPED;
        end else if (snoop_evt) begin
          state_d     = PS_SNOOP;
          snp_grant_d = 1'b1;
          inval_d     = 1'b1;
        end else if (!stop_req && cnt_done) begin
          if (ret_halt_q) begin
            state_d      = PS_HALTED;
            halt_pulse_d = 1'b1;
          end else begin
            state_d = PS_RUN;
          end
        end
      end
      PS_STOPPED: begin
        if (cnt_hit) state_d = PS_GRANT;
      end
      PS_SNOOP: begin
        state_d = snp_grant_q ? PS_GRANT : PS_HALTED;
      end
      default: state_d = PS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= PS_RUN;
      ret_halt_q    <= 1'b0;
      snp_grant_q   <= 1'b0;
      snoop_prev_q  <= 1'b0;
      stopgnt_cyc_q <= 1'b0;
      halt_cyc_q    <= 1'b0;
      inval_q       <= 1'b0;
    end else begin
      state_q       <= state_d;
      ret_halt_q    <= ret_halt_d;
      snp_grant_q   <= snp_grant_d;
      snoop_prev_q  <= snoop_act;
      stopgnt_cyc_q <= sg_pulse_d;
      halt_cyc_q    <= halt_pulse_d;
      inval_q       <= inval_d;
    end
  end

  // R2: a stop-grant cycle request appears only in stop-granted
  p_grant_pulse_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    stopgnt_cyc_q |-> (state_q == PS_GRANT));

  // R2: the stop-grant request lasts one cycle
  p_grant_single_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    stopgnt_cyc_q |=> !stopgnt_cyc_q);

  // R3: a halt cycle request appears only in halted
  p_halt_pulse_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    halt_cyc_q |-> (state_q == PS_HALTED));

  // R9: the snoop state lasts one cycle
  p_snoop_once_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == PS_SNOOP) |=> (state_q != PS_SNOOP));

  // R9: invalidation only while servicing a snoop
  p_inval_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    inval_q |-> (state_q == PS_SNOOP));

  // R8: leaving clock-stopped happens with the counter at the limit
  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    ((state_q == PS_GRANT) && ($past(state_q) == PS_STOPPED)) |->
      (cnt_q == CW'(LIMIT)));

  // R6: a release out of stop-granted needs the settle window
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (((state_q == PS_RUN) || (state_q == PS_HALTED)) &&
     ($past(state_q) == PS_GRANT)) |-> $past(cnt_done));

endmodule

// File: rtl/pwr_state_ctrl.sv
// Top: reset release, input synchronizers, restart counter and state machine.
module pwr_state_ctrl
  import pwr_pkg::*;
#(
  parameter int RESTART_CYCLES = 8,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_req_n,
  input  logic       halt_ind,
  input  logic       wake_intr,
  input  logic       wake_nmi,
  input  logic       wake_smi,
  input  logic       wake_rst,
  input  logic       wake_srst,
  input  logic       snoop_n,
  input  logic       clk_present,
  output logic [2:0] state_o,
  output logic       stopgnt_cyc_o,
  output logic       halt_cyc_o,
  output logic       inval_o,
  output logic       core_run_o
);

  localparam int CW     = $clog2(RESTART_CYCLES + 1);
  localparam int SYNC_W = NUM_WAKE + 2;

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // Input synchronizers: bit 0 stop request, bit 1 snoop, rest wakes.
  logic [SYNC_W-1:0]   sync_d, sync_q;
  logic [NUM_WAKE-1:0] wake_raw, wake_s;

  assign wake_raw = {wake_srst, wake_rst, wake_smi, wake_nmi, wake_intr};
  assign sync_d   = {wake_raw, snoop_n, stop_req_n};

  pwr_sync #(
    .W       (SYNC_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL ({{NUM_WAKE{1'b0}}, 2'b11})
  ) u_sync (
    .clk    (clk),
    .rst_ni (rst_ni),
    .d_i    (sync_d),
    .q_o    (sync_q)
  );

  logic [NUM_WAKE-1:0] wake_or;
  for (genvar k = 0; k < NUM_WAKE; k++) begin : g_wake
    assign wake_s[k] = sync_q[k+2];
    if (k == 0) begin : g_first
      assign wake_or[k] = wake_s[k];
    end else begin : g_rest
      assign wake_or[k] = wake_or[k-1] | wake_s[k];
    end
  end

  // Restart / settle counter
  logic          grant_entry, cnt_done, cnt_hit;
  logic [CW-1:0] cnt_q;

  pwr_restart_cnt #(
    .LIMIT (RESTART_CYCLES),
    .CW    (CW)
  ) u_cnt (
    .clk    (clk),
    .rst_ni (rst_ni),
    .clr_i  (grant_entry || !clk_present),
    .run_i  (clk_present),
    .cnt_o  (cnt_q),
    .done_o (cnt_done),
    .hit_o  (cnt_hit)
  );

  pwr_state_e state_q;

  pwr_fsm #(
    .LIMIT (RESTART_CYCLES),
    .CW    (CW)
  ) u_fsm (
    .clk           (clk),
    .rst_ni        (rst_ni),
    .stop_req      (!sync_q[0]),
    .halt_ind      (halt_ind),
    .wake_any      (wake_or[NUM_WAKE-1]),
    .snoop_act     (!sync_q[1]),
    .clk_present   (clk_present),
    .cnt_done      (cnt_done),
    .cnt_hit       (cnt_hit),
    .cnt_q         (cnt_q),
    .state_q       (state_q),
    .grant_entry   (grant_entry),
    .stopgnt_cyc_q (stopgnt_cyc_o),
    .halt_cyc_q    (halt_cyc_o),
    .inval_q       (inval_o)
  );

  assign state_o    = state_q;
  assign core_run_o = (state_q == PS_RUN);

  // R7: clock loss while stop-granted always reaches clock-stopped
  p_clock_loss_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    ((state_q == PS_GRANT) && !clk_present) |=> (state_q == PS_STOPPED));

  // R13: wakes alone never move the controller out of stop-granted
  p_wake_ignored_r13: assert property (@(posedge clk) disable iff (!rst_ni)
    ((state_q == PS_GRANT) && clk_present && !sync_q[0] && sync_q[1] &&
     wake_or[NUM_WAKE-1]) |=> (state_q == PS_GRANT));

endmodule

// File: tb/pwr_state_ctrl_test.sv
module pwr_state_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n, stop_req_n, halt_ind, snoop_n, clk_present;
  logic       wake_intr, wake_nmi, wake_smi, wake_rst, wake_srst;
  logic [2:0] state_o;
  logic       stopgnt_cyc_o, halt_cyc_o, inval_o, core_run_o;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  localparam logic [2:0] S_RUN = 3'd0, S_GRANT = 3'd1, S_STOP = 3'd2,
                         S_HALT = 3'd3, S_SNOOP = 3'd4;

  always #10 clk = ~clk;  // 50 MHz

  pwr_state_ctrl uut (
    .clk(clk), .rst_n(rst_n), .stop_req_n(stop_req_n), .halt_ind(halt_ind),
    .wake_intr(wake_intr), .wake_nmi(wake_nmi), .wake_smi(wake_smi),
    .wake_rst(wake_rst), .wake_srst(wake_srst), .snoop_n(snoop_n),
    .clk_present(clk_present), .state_o(state_o),
    .stopgnt_cyc_o(stopgnt_cyc_o), .halt_cyc_o(halt_cyc_o),
    .inval_o(inval_o), .core_run_o(core_run_o)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                     input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_halt();
    halt_ind = 1'b1;
    step(1);
    halt_ind = 1'b0;
  endtask

  task automatic set_wake(input int k, input logic v);
    case (k)
      0: wake_intr = v;
      1: wake_nmi  = v;
      2: wake_smi  = v;
      3: wake_rst  = v;
      default: wake_srst = v;
    endcase
  endtask

  // R1: state and outputs during and right after reset
  task automatic t_reset();
    step(1);
    chk(state_o, S_RUN, "R1 state in reset");
    chk({stopgnt_cyc_o, halt_cyc_o, inval_o}, 0, "R1 pulses in reset");
    chk(core_run_o, 1, "R1 run enable in reset");
    rst_n = 1'b1;
    step(4);
    chk(state_o, S_RUN, "R1 state after release");
  endtask

  // R12, R2, R6, R5, R11: run -> stop-granted -> run
  task automatic t_grant_from_run();
    stop_req_n = 1'b0;
    step(1);
    chk(state_o, S_RUN, "R12 no effect after first edge");
    step(1);
    chk(state_o, S_RUN, "R12 no effect after second edge");
    step(1);
    chk(state_o, S_GRANT, "R12 R2 stop-granted at third edge");
    chk(stopgnt_cyc_o, 1, "R2 stop-grant pulse");
    chk(core_run_o, 0, "R11 run enable off in stop-granted");
    step(1);
    chk(stopgnt_cyc_o, 0, "R2 pulse is one cycle");
    stop_req_n = 1'b1;
    step(7);
    chk(state_o, S_GRANT, "R6 held until window closes");
    step(1);
    chk(state_o, S_RUN, "R6 R5 release honoured, back to run");
    chk(halt_cyc_o, 0, "R5 no halt pulse on return to run");
    chk(core_run_o, 1, "R11 run enable in run");
  endtask

  // R2: stop request wins over halt at the same edge
  task automatic t_priority();
    stop_req_n = 1'b0;
    step(2);
    halt_ind = 1'b1;
    step(1);
    halt_ind = 1'b0;
    chk(state_o, S_GRANT, "R2 stop wins over halt");
    chk(halt_cyc_o, 0, "R2 no halt pulse when stop wins");
    stop_req_n = 1'b1;
    step(12);
    chk(state_o, S_RUN, "R5 return to run after priority case");
  endtask

  // R3, R4: halt then each wake source
  task automatic t_halt_wake();
    for (int k = 0; k < 5; k++) begin
      pulse_halt();
      chk(state_o, S_HALT, "R3 halted");
      chk(halt_cyc_o, 1, "R3 halt pulse");
      step(1);
      chk(halt_cyc_o, 0, "R3 halt pulse one cycle");
      set_wake(k, 1'b1);
      step(1);
      set_wake(k, 1'b0);
      step(2);
      chk(state_o, S_RUN, $sformatf("R4 wake source %0d", k));
    end
  endtask

  // R5, R6: halted -> stop-granted -> halted
  task automatic t_halt_grant();
    pulse_halt();
    step(1);
    stop_req_n = 1'b0;
    step(3);
    chk(state_o, S_GRANT, "R5 halted to stop-granted");
    chk(stopgnt_cyc_o, 1, "R5 stop-grant pulse from halted");
    stop_req_n = 1'b1;
    step(8);
    chk(state_o, S_GRANT, "R6 window from halted");
    step(1);
    chk(state_o, S_HALT, "R5 return to halted");
    chk(halt_cyc_o, 1, "R5 halt pulse re-issued");
    wake_intr = 1'b1;
    step(1);
    wake_intr = 1'b0;
    step(2);
    chk(state_o, S_RUN, "R4 wake after return");
  endtask

  // R13, R7, R8, R11: wakes ignored, clock stop and restart
  task automatic t_clock_stop();
    stop_req_n = 1'b0;
    step(3);
    chk(state_o, S_GRANT, "R13 in stop-granted");
    wake_smi = 1'b1;
    wake_nmi = 1'b1;
    step(1);
    wake_smi = 1'b0;
    wake_nmi = 1'b0;
    step(4);
    chk(state_o, S_GRANT, "R13 wakes ignored");
    clk_present = 1'b0;
    step(1);
    chk(state_o, S_STOP, "R7 clock-stopped");
    chk(core_run_o, 0, "R11 R7 run enable off when stopped");
    step(3);
    chk(state_o, S_STOP, "R7 stays stopped");
    clk_present = 1'b1;
    step(7);
    chk(state_o, S_STOP, "R8 still stopped after seven edges");
    step(1);
    chk(state_o, S_GRANT, "R8 stop-granted at eighth edge");
    stop_req_n = 1'b1;
    step(3);
    chk(state_o, S_RUN, "R5 release after restart");
  endtask

  // R9: snoop while halted
  task automatic t_snoop_halt();
    pulse_halt();
    step(1);
    snoop_n = 1'b0;
    step(1);
    snoop_n = 1'b1;
    step(2);
    chk(state_o, S_SNOOP, "R9 snoop from halted");
    chk(inval_o, 1, "R9 invalidate pulse");
    step(1);
    chk(state_o, S_HALT, "R9 back to halted");
    chk(inval_o, 0, "R9 invalidate one cycle");
    wake_rst = 1'b1;
    step(1);
    wake_rst = 1'b0;
    step(2);
    chk(state_o, S_RUN, "R4 leave halted after snoop");
  endtask

  // R9: snoop while stop-granted
  task automatic t_snoop_grant();
    stop_req_n = 1'b0;
    step(3);
    snoop_n = 1'b0;
    step(1);
    snoop_n = 1'b1;
    step(2);
    chk(state_o, S_SNOOP, "R9 snoop from stop-granted");
    chk(inval_o, 1, "R9 invalidate in stop-granted");
    step(1);
    chk(state_o, S_GRANT, "R9 back to stop-granted");
    stop_req_n = 1'b1;
    step(12);
    chk(state_o, S_RUN, "R5 release after snoop");
  endtask

  // R10: snoop in run has no effect
  task automatic t_snoop_run();
    snoop_n = 1'b0;
    step(1);
    snoop_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      step(1);
      chk(inval_o, 0, "R10 no invalidate in run");
      chk(state_o, S_RUN, "R10 state stays run");
    end
  endtask

  // R1: reset from a non-run state
  task automatic t_reset_mid();
    pulse_halt();
    chk(state_o, S_HALT, "R1 halted before reset");
    rst_n = 1'b0;
    #1;
    chk(state_o, S_RUN, "R1 asynchronous reset from halted");
    chk(halt_cyc_o, 0, "R1 halt pulse cleared");
    chk(core_run_o, 1, "R1 run enable after reset");
    step(1);
    rst_n = 1'b1;
    step(4);
    chk(state_o, S_RUN, "R1 run after second release");
  endtask

  initial begin
    rst_n = 1'b1; stop_req_n = 1'b1; halt_ind = 1'b0; snoop_n = 1'b1;
    clk_present = 1'b1; wake_intr = 1'b0; wake_nmi = 1'b0; wake_smi = 1'b0;
    wake_rst = 1'b0; wake_srst = 1'b0;
    #5 rst_n = 1'b0;
    t_reset();
    t_grant_from_run();
    t_priority();
    t_halt_wake();
    t_halt_grant();
    t_clock_stop();
    t_snoop_halt();
    t_snoop_grant();
    t_snoop_run();
    t_reset_mid();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule